// File: doc/BRIEF.md
# Sticky Imprecise Error Status Register

This block keeps a 32-bit status word that tells software which interconnect ports have returned error responses that could not be tied back to the transaction that caused them. There are two groups of seven ports: target-side ports and initiator-side ports. Each port has a one-cycle error pulse input. A pulse sets a sticky bit that stays set until software clears it. Software clears a bit by writing 1 to it. While any bit is set, a registered active-low interrupt line is held low.

Register accesses arrive on a simple select/write/data port. An external decoder drives this port. Each access carries a security attribute. Secure accesses are always served. A non-secure access is served only while the permit input is high. That input comes from a separate security-control register. When a non-secure access is refused, it returns zero data, changes nothing, and raises an access-error response for one cycle.

Top module: `imprecise_err_status`

## Requirements
- R1: While `rst` is high at a clock edge, every status bit clears. After that edge, `irq_n` is 1, and `rsp_valid`, `rsp_err` and `rd_data` are 0.
- R2: An `ini_err_pulse[k]` pulse sets status bit k, for k in 0..6. The bit then stays 1 until it is cleared by a write.
- R3: A `tgt_err_pulse[k]` pulse sets status bit 16+k, for k in 0..6. The bit then stays 1 until it is cleared by a write.
- R4: A permitted write clears every status bit whose `req_wdata` bit is 1. Status bits whose `req_wdata` bit is 0 keep their value.
- R5: If an error pulse and a clearing write hit the same bit in the same cycle, the bit ends up 1.
- R6: Bits 31..23 and 15..7 always read 0. Writing to them has no effect.
- R7: Every access (`req_valid` high) gives `rsp_valid` high in the next cycle only. A permitted read returns the status value from the cycle of the request in that next cycle. In every other cycle, `rd_data` is 0.
- R8: A non-secure access (`req_secure`=0) while `sec_permit`=0 is refused. A refused read returns 0. A refused write changes no bit. In both cases `rsp_err` is 1 in the cycle after the request, together with `rsp_valid`, and 0 otherwise.
- R9: While `sec_permit`=1, a non-secure access behaves exactly like a secure one.
- R10: `irq_n` is 0 in the cycle after any status bit is 1. It is 1 in the cycle after all status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Security attribute of the access, 1 = secure |
| req_wdata | input | 32 | Write data, 1 bits clear status bits |
| sec_permit | input | 1 | Allows non-secure accesses when high |
| ini_err_pulse | input | 7 | Per-port imprecise error pulses, initiator side |
| tgt_err_pulse | input | 7 | Per-port imprecise error pulses, target side |
| rsp_valid | output | 1 | Response strobe, one cycle after an access |
| rsp_err | output | 1 | Access refused by the security check |
| rd_data | output | 32 | Read data |
| irq_n | output | 1 | Interrupt, active low, registered |

## Verification
An error pulse and a clearing write can land on the same status bit in one clock edge. A read and a pulse can also fall in the same cycle. The bench provokes the first case directly: it writes 1 to a bit while the matching error pulse is high. It then reads the register back and expects the bit to still be 1. Random cycles then mix pulses with secure, permitted and refused reads and writes. A bench model updates the status word in the same order (clear, then set). Every cycle's response data, error flag and interrupt level are judged against that model.

// File: rtl/ierr_pkg.sv
package ierr_pkg;
  localparam int unsigned IERR_REG_W    = 32;
  localparam int unsigned IERR_PORTS    = 7;
  localparam int unsigned IERR_INI_LSB  = 0;
  localparam int unsigned IERR_TGT_LSB  = 16;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_DENY  = 2'd3
  } acc_kind_e;

  function automatic logic [IERR_REG_W-1:0] field_mask(input int unsigned lsb,
                                                       input int unsigned width);
    logic [IERR_REG_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < width; i++) m[lsb+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ierr_access_gate.sv
module ierr_access_gate
  import ierr_pkg::*;
(
  input  logic      req_valid,
  input  logic      req_write,
  input  logic      req_secure,
  input  logic      sec_permit,
  output acc_kind_e acc_kind
);
  logic allowed;
  assign allowed = req_secure | sec_permit;

  always_comb begin
    if (!req_valid)      acc_kind = ACC_IDLE;
    else if (!allowed)   acc_kind = ACC_DENY;
    else if (req_write)  acc_kind = ACC_WRITE;
    else                 acc_kind = ACC_READ;
  end
endmodule

// File: rtl/ierr_sticky_bank.sv
module ierr_sticky_bank #(
  parameter int unsigned PORTS = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PORTS-1:0] err_pulse,
  input  logic             clr_en,
  input  logic [PORTS-1:0] clr_mask,
  output logic [PORTS-1:0] bits_q
);
  for (genvar k = 0; k < PORTS; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)               bits_q[k] <= 1'b0;
      else if (err_pulse[k]) bits_q[k] <= 1'b1;   // set has priority over clear
      else if (clr_en && clr_mask[k]) bits_q[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/ierr_irq_gen.sv
module ierr_irq_gen #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] status,
  output logic         irq_n
);
  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~(|status);
  end
endmodule

// File: rtl/ierr_rsp_reg.sv
module ierr_rsp_reg
  import ierr_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  acc_kind_e    acc_kind,
  input  logic [W-1:0] status,
  output logic         rsp_valid,
  output logic         rsp_err,
  output logic [W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rd_data   <= '0;
    end else begin
      rsp_valid <= (acc_kind != ACC_IDLE);
      rsp_err   <= (acc_kind == ACC_DENY);
      rd_data   <= (acc_kind == ACC_READ) ? status : '0;
    end
  end
endmodule

// File: rtl/imprecise_err_status.sv
module imprecise_err_status
  import ierr_pkg::*;
#(
  parameter int unsigned REG_W   = IERR_REG_W,
  parameter int unsigned PORTS   = IERR_PORTS,
  parameter int unsigned INI_LSB = IERR_INI_LSB,
  parameter int unsigned TGT_LSB = IERR_TGT_LSB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_secure,
  input  logic [REG_W-1:0] req_wdata,
  input  logic             sec_permit,
  input  logic [PORTS-1:0] ini_err_pulse,
  input  logic [PORTS-1:0] tgt_err_pulse,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [REG_W-1:0] rd_data,
  output logic             irq_n
);
  localparam logic [REG_W-1:0] LIVE_MASK =
    REG_W'(field_mask(INI_LSB, PORTS) | field_mask(TGT_LSB, PORTS));

  acc_kind_e        acc_kind;
  logic [PORTS-1:0] ini_bits, tgt_bits;
  logic [REG_W-1:0] status_w;
  logic             clr_en;
  logic             unused_rsvd_wdata;

  assign clr_en = (acc_kind == ACC_WRITE);
  assign unused_rsvd_wdata = ^(req_wdata & ~LIVE_MASK);

  ierr_access_gate u_gate (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_secure(req_secure),
    .sec_permit(sec_permit),
    .acc_kind  (acc_kind)
  );

  ierr_sticky_bank #(.PORTS(PORTS)) u_ini_bank (
    .clk      (clk),
    .rst      (rst),
    .err_pulse(ini_err_pulse),
    .clr_en   (clr_en),
    .clr_mask (req_wdata[INI_LSB +: PORTS]),
    .bits_q   (ini_bits)
  );

  ierr_sticky_bank #(.PORTS(PORTS)) u_tgt_bank (
    .clk      (clk),
    .rst      (rst),
    .err_pulse(tgt_err_pulse),
    .clr_en   (clr_en),
    .clr_mask (req_wdata[TGT_LSB +: PORTS]),
    .bits_q   (tgt_bits)
  );

  always_comb begin
    status_w = '0;
    status_w[INI_LSB +: PORTS] = ini_bits;
    status_w[TGT_LSB +: PORTS] = tgt_bits;
  end

  ierr_rsp_reg #(.W(REG_W)) u_rsp (
    .clk      (clk),
    .rst      (rst),
    .acc_kind (acc_kind),
    .status   (status_w),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .rd_data  (rd_data)
  );

  ierr_irq_gen #(.W(REG_W)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .status(status_w),
    .irq_n (irq_n)
  );
endmodule

// File: rtl/ierr_checker.sv
module ierr_checker
  import ierr_pkg::*;
#(
  parameter int unsigned REG_W   = IERR_REG_W,
  parameter int unsigned PORTS   = IERR_PORTS,
  parameter int unsigned INI_LSB = IERR_INI_LSB,
  parameter int unsigned TGT_LSB = IERR_TGT_LSB
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_write,
  input logic             req_secure,
  input logic [REG_W-1:0] req_wdata,
  input logic             sec_permit,
  input logic [PORTS-1:0] ini_err_pulse,
  input logic [PORTS-1:0] tgt_err_pulse,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic [REG_W-1:0] rd_data,
  input logic             irq_n,
  input logic [REG_W-1:0] status
);
  localparam logic [REG_W-1:0] RSVD_MASK =
    ~REG_W'(field_mask(INI_LSB, PORTS) | field_mask(TGT_LSB, PORTS));

  logic wr_ok, denied;
  assign wr_ok  = req_valid && req_write && (req_secure || sec_permit);
  assign denied = req_valid && !req_secure && !sec_permit;

  for (genvar k = 0; k < PORTS; k++) begin : g_port
    AST_INI_SET: assert property (@(posedge clk) disable iff (rst)
      ini_err_pulse[k] |=> status[INI_LSB+k]);  // R2
    AST_TGT_SET: assert property (@(posedge clk) disable iff (rst)
      tgt_err_pulse[k] |=> status[TGT_LSB+k]);  // R3
    AST_INI_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (wr_ok && req_wdata[INI_LSB+k] && !ini_err_pulse[k]) |=> !status[INI_LSB+k]);  // R4
    AST_TGT_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (wr_ok && req_wdata[TGT_LSB+k] && !tgt_err_pulse[k]) |=> !status[TGT_LSB+k]);  // R4
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_data & RSVD_MASK) == '0);  // R6
  AST_RSP_STROBE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);  // R7
  AST_DENY_RESP: assert property (@(posedge clk) disable iff (rst)
    denied |=> (rsp_err && rsp_valid && rd_data == '0));  // R8
  AST_DENY_KEEP: assert property (@(posedge clk) disable iff (rst)
    (denied && ini_err_pulse == '0 && tgt_err_pulse == '0) |=> $stable(status));  // R8
  AST_IRQ_LOW: assert property (@(posedge clk) disable iff (rst)
    (|status) |=> !irq_n);  // R10
  AST_IRQ_HIGH: assert property (@(posedge clk) disable iff (rst)
    (status == '0) |=> irq_n);  // R10
endmodule

bind imprecise_err_status ierr_checker #(
  .REG_W(REG_W), .PORTS(PORTS), .INI_LSB(INI_LSB), .TGT_LSB(TGT_LSB)
) u_ierr_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_secure(req_secure), .req_wdata(req_wdata), .sec_permit(sec_permit),
  .ini_err_pulse(ini_err_pulse), .tgt_err_pulse(tgt_err_pulse),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rd_data(rd_data),
  .irq_n(irq_n), .status(status_w)
);

// File: tb/imprecise_err_status_tb.sv
`timescale 1ns/1ps
module imprecise_err_status_tb;
  localparam int W = 32;
  localparam logic [W-1:0] LIVE = 32'h007F_007F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_write = 0, req_secure = 0, sec_permit = 0;
  logic [W-1:0] req_wdata = '0;
  logic [6:0] ini_err_pulse = '0, tgt_err_pulse = '0;
  logic rsp_valid, rsp_err, irq_n;
  logic [W-1:0] rd_data;

  int n_run = 0, n_fail = 0;
  logic [W-1:0] m_status = '0;

  always #2 clk = ~clk;  // 250 MHz

  imprecise_err_status u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_secure(req_secure), .req_wdata(req_wdata), .sec_permit(sec_permit),
    .ini_err_pulse(ini_err_pulse), .tgt_err_pulse(tgt_err_pulse),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rd_data(rd_data), .irq_n(irq_n)
  );

  function automatic logic [W-1:0] f_next(input logic [W-1:0] cur, input logic ok_wr,
                                          input logic [W-1:0] wd, input logic [6:0] ini,
                                          input logic [6:0] tgt);
    logic [W-1:0] clr, set;
    clr = ok_wr ? (wd & LIVE) : '0;
    set = {9'd0, tgt, 9'd0, ini};
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [W-1:0] f_rd(input logic [W-1:0] cur, input logic ok_rd);
    return ok_rd ? cur : '0;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic v, input logic wr, input logic sec,
                     input logic perm, input logic [W-1:0] wd, input logic [6:0] ini,
                     input logic [6:0] tgt);
    logic ok;
    logic [W-1:0] old;
    @(negedge clk);
    req_valid = v; req_write = wr; req_secure = sec; sec_permit = perm;
    req_wdata = wd; ini_err_pulse = ini; tgt_err_pulse = tgt;
    @(posedge clk);
    old = m_status;
    ok = v && (sec || perm);
    m_status = f_next(old, ok && wr, wd, ini, tgt);
    #1;
    chk(tag, rd_data, f_rd(old, ok && !wr));
    chk("R7 rsp_valid", {31'd0, rsp_valid}, {31'd0, v});
    chk("R8 rsp_err", {31'd0, rsp_err}, {31'd0, v && !(sec || perm)});
    chk("R10 irq_n", {31'd0, irq_n}, {31'd0, ~(|old)});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 0; ini_err_pulse = '0; tgt_err_pulse = '0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 irq_n", {31'd0, irq_n}, 32'd1);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 rsp_err", {31'd0, rsp_err}, 32'd0);
    chk("R1 rd_data", rd_data, '0);
    m_status = '0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic rd(input string tag, input logic sec, input logic perm);
    cyc(tag, 1, 0, sec, perm, '0, '0, '0);
  endtask

  task automatic wr(input string tag, input logic sec, input logic perm, input logic [W-1:0] wd);
    cyc(tag, 1, 1, sec, perm, wd, '0, '0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [W-1:0] wd;
    void'($urandom(32'd5179));
    do_reset();
    rd("R1 status after reset", 1, 0);
    // R2: initiator port 3, sticky
    cyc("R2 pulse cycle", 0, 0, 0, 0, '0, 7'h08, '0);
    rd("R2 set", 1, 0);
    rd("R2 sticky", 1, 0);
    // R3: target ports 6 and 0 -> bits 22 and 16
    cyc("R3 pulse cycle", 0, 0, 0, 0, '0, '0, 7'h41);
    rd("R3 set", 1, 0);
    // R4: clear bit 3, then a write of 0 changes nothing
    wr("R4 clear write", 1, 0, 32'h0000_0008);
    rd("R4 after clear", 1, 0);
    wr("R4 zero write", 1, 0, 32'h0);
    rd("R4 after zero write", 1, 0);
    // R5: clear bit 22 while its pulse fires
    cyc("R5 collide", 1, 1, 1, 0, 32'h0040_0000, '0, 7'h40);
    rd("R5 set wins", 1, 0);
    // R6: writes to reserved bits only
    wr("R6 reserved write", 1, 0, ~LIVE);
    rd("R6 reserved read", 1, 0);
    // R8: refused read and write
    rd("R8 refused read", 0, 0);
    wr("R8 refused write", 0, 0, 32'hFFFF_FFFF);
    rd("R8 state kept", 1, 0);
    // R9: permitted non-secure read and clear
    rd("R9 permitted read", 0, 1);
    wr("R9 permitted write", 0, 1, 32'hFFFF_FFFF);
    rd("R9 after clear", 0, 1);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] ini, tgt;
      ini = '0; tgt = '0;
      for (int k = 0; k < 7; k++) begin
        ini[k] = ($urandom % 10) == 0;
        tgt[k] = ($urandom % 10) == 0;
      end
      wd = $urandom;
      cyc("R7 random", ($urandom % 3) != 0, $urandom % 2, $urandom % 2,
          $urandom % 2, wd, ini, tgt);
    end
    // R1: reset with bits set
    cyc("R1 preload", 0, 0, 0, 0, '0, 7'h7F, 7'h7F);
    do_reset();
    rd("R1 status after second reset", 1, 0);
    cyc("R10 idle", 0, 0, 0, 0, '0, '0, '0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule